// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the 32-bit status and control word of a floating-point unit. It keeps four condition flags produced by a compare unit and six sticky exception bits. It also holds a two-bit rounding-mode field and two mode enables: flush-to-zero and default-NaN. Integer-side software replaces the whole word with one write and reads the whole word back. The rounding mode and the two mode enables drive the arithmetic units as plain control outputs. A separate output presents only the four condition flags, so that the core can copy them into its application status register.

The condition flags have only two sources: a result from the compare unit, or a software write. Arithmetic units never change them. Each arithmetic unit sends a per-operation exception vector. The block ORs the vectors from all units into the sticky bits every cycle, and the sticky bits stay set until software overwrites them. A software write must wait until earlier operations have retired. When a write arrives while the busy input is high, the block holds it and applies it in the first cycle that busy is low.

Top module: `fp_ctrl_status`

## Requirements
- R1: After reset, every bit of the read word is 0 and the rounding, flush and NaN-mode outputs are 0.
- R2: The read word places the flags as N=31, Z=30, C=29 and V=28. The mode enables sit at default-NaN=25 and flush-to-zero=24, and the rounding field at [23:22]. The sticky bits sit at input-denormal=7, inexact=4, underflow=3, overflow=2, divide-by-zero=1 and invalid=0. Every other bit reads 0, and writes to those bits have no effect.
- R3: A write with busy low replaces all defined bits, and the read word shows the written value from the next cycle on.
- R4: A write while busy is high leaves the word unchanged as long as busy stays high. If several writes arrive during that time, the last one is kept. It is applied in the first cycle that busy is low and is visible in the following cycle.
- R5: When cmp_valid is high, cmp_flags (bit 3=N, 2=Z, 1=C, 0=V) is loaded into bits [31:28] for the next cycle. No other bit changes.
- R6: Exception pulses never change bits [31:28]. The flags keep their value in every cycle that has neither a compare nor a write.
- R7: Each unit's exception slice is 6 bits wide: bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow, bit4 inexact, bit5 input-denormal. Unit k occupies exc_pulse[6k+5:6k]. A 1 in any slice from any unit sets the matching sticky bit in the next cycle.
- R8: A sticky bit stays set through idle cycles and compares until a software write clears it.
- R9: When a write is applied in the same cycle as an exception pulse, the sticky bits become the written value ORed with the pulse.
- R10: When a write is applied in the same cycle as a compare result, the written flags win.
- R11: round_mode, flush_zero and default_nan always equal bits [23:22], 24 and 25 of the read word. Round mode 2'b00 selects round-to-nearest-even and 2'b11 selects round-toward-zero.
- R12: nzcv_copy always equals bits [31:28] of the read word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software full-word write strobe |
| wr_data | input | 32 | Software write value |
| busy | input | 1 | High while earlier operations are still in flight |
| rd_data | output | 32 | Full register word |
| cmp_valid | input | 1 | Compare result valid |
| cmp_flags | input | 4 | Compare flags {N,Z,C,V} |
| exc_pulse | input | 6*NUM_UNITS | Per-unit exception pulses |
| round_mode | output | 2 | Rounding-mode control |
| flush_zero | output | 1 | Flush-to-zero enable |
| default_nan | output | 1 | Default-NaN enable |
| nzcv_copy | output | 4 | Flags presented for transfer to the application status register |

## Verification
The bench builds the block with its default of three exception units. With three units, the bench can sweep every pulse bit of every unit one at a time and check that each lands at its own sticky position. It also sweeps all 16 compare flag patterns and all 16 combinations of the mode and rounding field. The remaining cases are targeted ones: a write held across several busy cycles, two writes during busy where the last one must win, and a write applied in the same cycle as a pulse or as a compare.

// File: rtl/fp_ctrl_status_pkg.sv
package fp_ctrl_status_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned EXC_W   = 6;
  localparam int unsigned FLAG_LO = 28;
  localparam int unsigned CTRL_LO = 22;
  localparam int unsigned IDN_POS = 7;
  localparam logic [WORD_W-1:0] RSVD_MASK = 32'h0C3F_FF60;
endpackage

// File: rtl/fcs_write_hold.sv
module fcs_write_hold
  import fp_ctrl_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  output logic              commit,
  output logic [WORD_W-1:0] commit_data
);
  logic              pend_q, pend_n;
  logic [WORD_W-1:0] hold_q;
  logic              hold_en;

  always_comb begin
    hold_en     = wr_en & busy;
    commit      = ~busy & (wr_en | pend_q);
    commit_data = wr_en ? wr_data : hold_q;
    pend_n      = pend_q;
    if (hold_en)   pend_n = 1'b1;
    else if (~busy) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_q <= wr_data;
  end

  AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit); // R4
  AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !busy) |-> commit); // R4
endmodule

// File: rtl/fcs_exc_merge.sv
module fcs_exc_merge
  import fp_ctrl_status_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 3
) (
  input  logic [EXC_W*NUM_UNITS-1:0] exc_pulse,
  output logic [EXC_W-1:0]           exc_any
);
  logic [EXC_W-1:0] part [NUM_UNITS+1];

  assign part[0] = '0;
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign part[u+1] = part[u] | exc_pulse[u*EXC_W +: EXC_W];
  end
  assign exc_any = part[NUM_UNITS];
endmodule

// File: rtl/fp_ctrl_status.sv
module fp_ctrl_status
  import fp_ctrl_status_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [31:0]                wr_data,
  input  logic                       busy,
  output logic [31:0]                rd_data,
  input  logic                       cmp_valid,
  input  logic [3:0]                 cmp_flags,
  input  logic [6*NUM_UNITS-1:0]     exc_pulse,
  output logic [1:0]                 round_mode,
  output logic                       flush_zero,
  output logic                       default_nan,
  output logic [3:0]                 nzcv_copy
);
  logic              commit;
  logic [WORD_W-1:0] commit_data;
  logic [EXC_W-1:0]  exc_any;

  logic [3:0]       flag_q, flag_n;
  logic [3:0]       ctrl_q, ctrl_n;
  logic [EXC_W-1:0] cum_q, cum_n, cum_base;

  fcs_write_hold u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .busy(busy), .commit(commit), .commit_data(commit_data)
  );

  fcs_exc_merge #(.NUM_UNITS(NUM_UNITS)) u_merge (
    .exc_pulse(exc_pulse), .exc_any(exc_any)
  );

  always_comb begin
    flag_n   = flag_q;
    ctrl_n   = ctrl_q;
    cum_base = cum_q;
    if (commit) begin
      flag_n   = commit_data[FLAG_LO +: 4];
      ctrl_n   = commit_data[CTRL_LO +: 4];
      cum_base = {commit_data[IDN_POS], commit_data[4:0]};
    end else if (cmp_valid) begin
      flag_n   = cmp_flags;
    end
    cum_n = cum_base | exc_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ctrl_q <= '0;
      cum_q  <= '0;
    end else begin
      flag_q <= flag_n;
      ctrl_q <= ctrl_n;
      cum_q  <= cum_n;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[FLAG_LO +: 4] = flag_q;
    rd_data[CTRL_LO +: 4] = ctrl_q;
    rd_data[IDN_POS]      = cum_q[5];
    rd_data[4:0]          = cum_q[4:0];
  end

  assign round_mode  = ctrl_q[1:0];
  assign flush_zero  = ctrl_q[2];
  assign default_nan = ctrl_q[3];
  assign nzcv_copy   = flag_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSVD_MASK) == '0); // R2
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !commit) |=> $stable(nzcv_copy)); // R6
  AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !commit) |=> nzcv_copy == $past(cmp_flags)); // R5
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (cum_q & $past(cum_q)) == $past(cum_q)); // R8
  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cum_q & $past(exc_any)) == $past(exc_any)); // R7
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({default_nan, flush_zero, round_mode})); // R11
endmodule

// File: tb/fp_ctrl_status_test.sv
module fp_ctrl_status_test;
  localparam int NU = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, busy, cmp_valid;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  cmp_flags;
  logic [6*NU-1:0] exc_pulse;
  logic [1:0]  round_mode;
  logic        flush_zero, default_nan;
  logic [3:0]  nzcv_copy;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  fp_ctrl_status #(.NUM_UNITS(NU)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
    .rd_data(rd_data), .cmp_valid(cmp_valid), .cmp_flags(cmp_flags),
    .exc_pulse(exc_pulse), .round_mode(round_mode), .flush_zero(flush_zero),
    .default_nan(default_nan), .nzcv_copy(nzcv_copy)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stick_pos(input int b);
    return (b == 5) ? 32'h80 : (32'h1 << b);
  endfunction

  task automatic sw_write(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0;
  endtask

  task automatic chk_outs(input string req, input logic [31:0] w);
    chk(req, {30'd0, round_mode}, {30'd0, w[23:22]});
    chk(req, {31'd0, flush_zero}, {31'd0, w[24]});
    chk(req, {31'd0, default_nan}, {31'd0, w[25]});
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = '0; busy = 0; cmp_valid = 0;
    cmp_flags = '0; exc_pulse = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1", rd_data, 32'h0);
    chk_outs("R1", 32'h0);

    // R2/R3: all ones keeps only defined bits
    sw_write(32'hFFFF_FFFF);
    chk("R2", rd_data, 32'hF3C0_009F);
    chk("R12", {28'd0, nzcv_copy}, 32'hF);
    chk_outs("R11", 32'hF3C0_009F);
    // R2: reserved-only write clears everything
    sw_write(32'h0C3F_FF60);
    chk("R2", rd_data, 32'h0);

    // R3/R11 sweep of mode and rounding field
    for (int v = 0; v < 16; v++) begin
      sw_write(32'(v) << 22);
      chk("R3", rd_data, 32'(v) << 22);
      chk_outs("R11", 32'(v) << 22);
    end

    // R5/R12 sweep of compare flags
    sw_write(32'h00C0_0000);
    for (int f = 0; f < 16; f++) begin
      cmp_valid = 1'b1; cmp_flags = 4'(f); tick(); cmp_valid = 1'b0;
      chk("R5", rd_data, (32'(f) << 28) | 32'h00C0_0000);
      chk("R12", {28'd0, nzcv_copy}, 32'(f));
    end

    // R7/R6/R8 sweep of each unit and bit
    for (int u = 0; u < NU; u++) begin
      for (int b = 0; b < 6; b++) begin
        sw_write(32'h6000_0000);
        exc_pulse = '0; exc_pulse[u*6+b] = 1'b1; tick(); exc_pulse = '0;
        chk("R7", rd_data, 32'h6000_0000 | stick_pos(b));
        chk("R6", {28'd0, nzcv_copy}, 32'h6);
        tick(); tick();
        cmp_valid = 1'b1; cmp_flags = 4'h9; tick(); cmp_valid = 1'b0;
        chk("R8", rd_data, 32'h9000_0000 | stick_pos(b));
      end
    end

    // R7 accumulation across units in one cycle
    sw_write(32'h0);
    exc_pulse = '0; exc_pulse[0] = 1'b1; exc_pulse[6+2] = 1'b1; exc_pulse[12+5] = 1'b1;
    tick(); exc_pulse = '0;
    chk("R7", rd_data, 32'h85);
    // R8 software write clears
    sw_write(32'h0);
    chk("R8", rd_data, 32'h0);

    // R9 write and pulse together
    wr_en = 1'b1; wr_data = 32'h00C0_0010; exc_pulse[6+0] = 1'b1;
    tick(); wr_en = 1'b0; exc_pulse = '0;
    chk("R9", rd_data, 32'h00C0_0011);

    // R10 write and compare together
    wr_en = 1'b1; wr_data = 32'h5000_0000; cmp_valid = 1'b1; cmp_flags = 4'hA;
    tick(); wr_en = 1'b0; cmp_valid = 1'b0;
    chk("R10", rd_data, 32'h5000_0000);

    // R4 held write, last one wins
    busy = 1'b1;
    sw_write(32'h0100_0000);
    chk("R4", rd_data, 32'h5000_0000);
    sw_write(32'h0280_0000);
    chk("R4", rd_data, 32'h5000_0000);
    tick();
    chk("R4", rd_data, 32'h5000_0000);
    cmp_valid = 1'b1; cmp_flags = 4'h3; tick(); cmp_valid = 1'b0;
    chk("R5", rd_data, 32'h3000_0000);
    busy = 1'b0;
    tick();
    chk("R4", rd_data, 32'h0280_0000);
    chk_outs("R11", 32'h0280_0000);
    tick();
    chk("R4", rd_data, 32'h0280_0000);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule